// File: doc/BRIEF.md
# Masked Operation Dispatch Controller

This block sits between an instruction-driven register file and a pipelined accelerator that computes on two-share masked secrets. Software loads four 256-bit input share registers (two shares of each of two operands), then writes a control register with an operation code and a start bit. The block then streams the inputs into the accelerator as eight 32-bit lanes, one lane per cycle, lowest lane first. Results come back one lane at a time on a valid strobe and are stored, in lane order, into two 256-bit result share registers.

A status register exposes two flags. Ready drops at start and comes back as soon as the last input lane has been pushed, so the next inputs can be loaded while results are still in flight. Busy stays set until the eighth result lane has landed. Every write is checked against these flags; an illegal write is dropped and reported with a one-cycle error pulse. A pulse on the engine-start input returns control and status to their initial state.

Top module: `mask_dispatch_ctrl`

## Requirements
- R1: Control register reads as {29 zeros, op[1:0], 0}: bit 0 is the start bit and always reads 0, bits 2:1 hold the operation (0, 1, 2 are valid, 3 is invalid), bits 31:3 ignore writes and read 0.
- R2: Status register reads as {30 zeros, ready, busy} (busy at bit 0, ready at bit 1); writes to it change nothing and raise no error.
- R3: After reset or an engine-start pulse, the operation is 0, busy is 0 and ready is 1, and any run in progress is abandoned.
- R4: A legal control write with bit 0 set makes busy 1 and ready 0 from the clock edge that accepts it.
- R5: Starting the cycle after the start edge, one lane per cycle is pushed for lanes 0..7 in order, lane i being bits [32i+31:32i] of all four input registers, with the operation select equal to the stored operation.
- R6: Ready returns to 1 at the edge that accepts the eighth push, while busy is still 1.
- R7: Each valid result is stored into lane k of both result registers, k counting 0..7; busy clears at the edge that stores lane 7.
- R8: Result lanes not yet overwritten in the current run keep the values of the previous run.
- R9: A control write that sets start while busy, carries operation 3, or changes the operation while busy is not applied and makes the error output high for the one cycle after the write edge.
- R10: A write to an input register while ready is 0 is not applied and raises the error; while ready is 1 it is applied with no error, even if busy is 1.
- R11: Result strobes that arrive while busy is 0 are ignored.
- R12: Write target encoding: 0 control, 1 status, 2 operand 0 share 0, 3 operand 0 share 1, 4 operand 1 share 0, 5 operand 1 share 1; targets 6 and 7 are ignored without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| eng_start_i | input | 1 | Engine start: reinitialise control and status |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target (R12) |
| wr_data_i | input | 256 | Write data; control uses bits 2:0 |
| ctrl_rd_o | output | 32 | Control register read value |
| status_rd_o | output | 32 | Status register read value |
| res0_o | output | 256 | Result share 0 |
| res1_o | output | 256 | Result share 1 |
| err_o | output | 1 | Illegal-access pulse |
| acc_push_o | output | 1 | Lane push to accelerator |
| acc_op_o | output | 2 | Operation select to accelerator |
| acc_a0_o | output | 32 | Operand 0 share 0 lane |
| acc_a1_o | output | 32 | Operand 0 share 1 lane |
| acc_b0_o | output | 32 | Operand 1 share 0 lane |
| acc_b1_o | output | 32 | Operand 1 share 1 lane |
| acc_valid_i | input | 1 | Result lane valid |
| acc_r0_i | input | 32 | Result share 0 lane |
| acc_r1_i | input | 32 | Result share 1 lane |

## Verification
The bench builds the block with its default 32-bit lanes and eight lanes, and pairs it with an accelerator model of latency three. That latency is shorter than the dispatch length, so writeback overlaps dispatch, and the window in which ready is back but busy is still set lasts three cycles; this lets the bench check partially overwritten results and a legal input write during that window. An engine-start pulse mid-run leaves result strobes still in flight, which brings the gating of stray results within reach.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  localparam int unsigned CSR_W  = 32;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned NSHARE = 4;

  typedef enum logic [1:0] {
    OP_A2B    = 2'd0,
    OP_B2A    = 2'd1,
    OP_SECADD = 2'd2,
    OP_BAD    = 2'd3
  } op_e;

  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd1;
  localparam logic [SEL_W-1:0] SEL_IN0  = 3'd2;
endpackage

// File: rtl/mdc_ctrl.sv
module mdc_ctrl
  import mdc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       eng_start_i,
  input  logic       ctrl_wr_i,
  input  logic       in_wr_i,
  input  logic       wr_start_i,
  input  logic [1:0] wr_op_i,
  input  logic       disp_done_i,
  input  logic       wb_done_i,
  output op_e        op_o,
  output logic       busy_o,
  output logic       ready_o,
  output logic       start_o,
  output logic       in_ok_o,
  output logic       err_o
);
  op_e  op_q;
  logic busy_q, ready_q, err_q;
  logic ctrl_bad, in_bad, ctrl_ok;

  assign ctrl_bad = ctrl_wr_i &&
                    (wr_op_i == OP_BAD ||
                     (busy_q && (wr_start_i || wr_op_i != op_q)));
  assign in_bad   = in_wr_i && !ready_q;
  assign ctrl_ok  = ctrl_wr_i && !ctrl_bad && !eng_start_i;
  assign start_o  = ctrl_ok && wr_start_i;
  assign in_ok_o  = in_wr_i && ready_q && !eng_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_A2B;
      busy_q  <= 1'b0;
      ready_q <= 1'b1;
      err_q   <= 1'b0;
    end else if (eng_start_i) begin
      op_q    <= OP_A2B;
      busy_q  <= 1'b0;
      ready_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= ctrl_bad || in_bad;
      if (ctrl_ok) op_q <= op_e'(wr_op_i);
      if (start_o)        busy_q <= 1'b1;
      else if (wb_done_i) busy_q <= 1'b0;
      if (start_o)          ready_q <= 1'b0;
      else if (disp_done_i) ready_q <= 1'b1;
    end
  end

  assign op_o    = op_q;
  assign busy_o  = busy_q;
  assign ready_o = ready_q;
  assign err_o   = err_q;

  assert_start_sets_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (busy_q && !ready_q));
  assert_idle_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> ready_q);
  assert_err_from_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> $past(ctrl_wr_i || in_wr_i));
endmodule

// File: rtl/mdc_dispatch.sv
module mdc_dispatch #(
  parameter int unsigned LANES  = 8,
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  output logic             push_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  assign push_o = active_q;
  assign idx_o  = idx_q;
  assign done_o = active_q && (idx_q == IDX_W'(LANES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      idx_q <= done_o ? '0 : idx_q + 1'b1;
      if (done_o) active_q <= 1'b0;
    end
  end

  assert_first_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !abort_i) |=> (push_o && idx_q == '0));
  assert_idle_idx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> idx_q == '0);
endmodule

// File: rtl/mdc_writeback.sv
module mdc_writeback #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 8,
  localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [LANE_W-1:0] r0_i,
  input  logic [LANE_W-1:0] r1_i,
  output logic [DATA_W-1:0] res0_o,
  output logic [DATA_W-1:0] res1_o,
  output logic              done_o
);
  logic [IDX_W-1:0] idx_q;
  logic             accept;

  assign accept = valid_i && en_i && !abort_i;
  assign done_o = accept && (idx_q == IDX_W'(LANES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (abort_i) idx_q <= '0;
    else if (accept)  idx_q <= done_o ? '0 : idx_q + 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] s0_q, s1_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s0_q <= '0;
        s1_q <= '0;
      end else if (accept && idx_q == IDX_W'(g)) begin
        s0_q <= r0_i;
        s1_q <= r1_i;
      end
    end
    assign res0_o[g*LANE_W +: LANE_W] = s0_q;
    assign res1_o[g*LANE_W +: LANE_W] = s1_q;
  end

  assert_stray_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !en_i) |=> ($stable(res0_o) && $stable(res1_o)));
endmodule

// File: rtl/mask_dispatch_ctrl.sv
module mask_dispatch_ctrl
  import mdc_pkg::*;
#(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 8,
  localparam int unsigned DATA_W = LANE_W * LANES,
  localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eng_start_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CSR_W-1:0]  ctrl_rd_o,
  output logic [CSR_W-1:0]  status_rd_o,
  output logic [DATA_W-1:0] res0_o,
  output logic [DATA_W-1:0] res1_o,
  output logic              err_o,
  output logic              acc_push_o,
  output logic [1:0]        acc_op_o,
  output logic [LANE_W-1:0] acc_a0_o,
  output logic [LANE_W-1:0] acc_a1_o,
  output logic [LANE_W-1:0] acc_b0_o,
  output logic [LANE_W-1:0] acc_b1_o,
  input  logic              acc_valid_i,
  input  logic [LANE_W-1:0] acc_r0_i,
  input  logic [LANE_W-1:0] acc_r1_i
);
  op_e              op;
  logic             busy, ready, start, in_ok;
  logic             disp_done, wb_done;
  logic             ctrl_wr, in_wr;
  logic [IDX_W-1:0] disp_idx;
  logic [LANE_W-1:0] lane_w [NSHARE];

  assign ctrl_wr = wr_en_i && wr_sel_i == SEL_CTRL;
  assign in_wr   = wr_en_i && wr_sel_i >= SEL_IN0 &&
                   wr_sel_i < SEL_W'(int'(SEL_IN0) + NSHARE);

  mdc_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eng_start_i (eng_start_i),
    .ctrl_wr_i   (ctrl_wr),
    .in_wr_i     (in_wr),
    .wr_start_i  (wr_data_i[0]),
    .wr_op_i     (wr_data_i[2:1]),
    .disp_done_i (disp_done),
    .wb_done_i   (wb_done),
    .op_o        (op),
    .busy_o      (busy),
    .ready_o     (ready),
    .start_o     (start),
    .in_ok_o     (in_ok),
    .err_o       (err_o)
  );

  mdc_dispatch #(.LANES(LANES)) u_disp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (eng_start_i),
    .start_i (start),
    .push_o  (acc_push_o),
    .idx_o   (disp_idx),
    .done_o  (disp_done)
  );

  mdc_writeback #(.LANE_W(LANE_W), .LANES(LANES)) u_wb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (eng_start_i),
    .en_i    (busy),
    .valid_i (acc_valid_i),
    .r0_i    (acc_r0_i),
    .r1_i    (acc_r1_i),
    .res0_o  (res0_o),
    .res1_o  (res1_o),
    .done_o  (wb_done)
  );

  for (genvar g = 0; g < NSHARE; g++) begin : g_in
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(int'(SEL_IN0) + g);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       q <= '0;
      else if (in_ok && wr_sel_i == MY_SEL) q <= wr_data_i;
    end
    assign lane_w[g] = q[int'(disp_idx)*LANE_W +: LANE_W];
  end

  assign acc_a0_o = lane_w[0];
  assign acc_a1_o = lane_w[1];
  assign acc_b0_o = lane_w[2];
  assign acc_b1_o = lane_w[3];
  assign acc_op_o = op;

  assign ctrl_rd_o   = {{(CSR_W-3){1'b0}}, op, 1'b0};
  assign status_rd_o = {{(CSR_W-2){1'b0}}, ready, busy};

  assert_push_not_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_push_o |-> !ready);
  assert_busy_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> $past(wb_done || eng_start_i));
  assert_push_op_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_push_o && !eng_start_i) |=> $stable(acc_op_o));
endmodule

// File: tb/mask_dispatch_ctrl_tb_top.sv
module mask_dispatch_ctrl_tb_top;
  localparam int LW  = 32;
  localparam int NL  = 8;
  localparam int DW  = LW * NL;
  localparam int LAT = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          eng_start_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [2:0]    wr_sel_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [31:0]   ctrl_rd_o, status_rd_o;
  logic [DW-1:0] res0_o, res1_o;
  logic          err_o, acc_push_o;
  logic [1:0]    acc_op_o;
  logic [LW-1:0] acc_a0_o, acc_a1_o, acc_b0_o, acc_b1_o;
  logic          acc_valid_i;
  logic [LW-1:0] acc_r0_i, acc_r1_i;

  int checks = 0;
  int failures = 0;
  logic last_err;
  logic [DW-1:0] sh [4];
  logic [DW-1:0] exp_r0, exp_r1;

  always #5 clk_i = ~clk_i;

  mask_dispatch_ctrl dut_i (.*);

  // accelerator model: fixed latency LAT
  logic          pv [LAT];
  logic [LW-1:0] p0 [LAT];
  logic [LW-1:0] p1 [LAT];

  function automatic logic [LW-1:0] f0(logic [LW-1:0] a0, logic [LW-1:0] b0, logic [1:0] op);
    return a0 + b0 + {30'b0, op};
  endfunction
  function automatic logic [LW-1:0] f1(logic [LW-1:0] a1, logic [LW-1:0] b1, logic [1:0] op);
    return a1 ^ b1 ^ {op, 30'h15a5a5a5};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LAT; k++) begin pv[k] <= 1'b0; p0[k] <= '0; p1[k] <= '0; end
    end else begin
      pv[0] <= acc_push_o;
      p0[0] <= f0(acc_a0_o, acc_b0_o, acc_op_o);
      p1[0] <= f1(acc_a1_o, acc_b1_o, acc_op_o);
      for (int k = 1; k < LAT; k++) begin pv[k] <= pv[k-1]; p0[k] <= p0[k-1]; p1[k] <= p1[k-1]; end
    end
  end
  assign acc_valid_i = pv[LAT-1];
  assign acc_r0_i    = p0[LAT-1];
  assign acc_r1_i    = p1[LAT-1];

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd256();
    logic [DW-1:0] v;
    for (int i = 0; i < NL; i++) v[i*LW +: LW] = $urandom;
    return v;
  endfunction

  function automatic void calc(input logic [1:0] op, output logic [DW-1:0] r0, output logic [DW-1:0] r1);
    for (int i = 0; i < NL; i++) begin
      r0[i*LW +: LW] = f0(sh[0][i*LW +: LW], sh[2][i*LW +: LW], op);
      r1[i*LW +: LW] = f1(sh[1][i*LW +: LW], sh[3][i*LW +: LW], op);
    end
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [DW-1:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    last_err = err_o;
  endtask

  task automatic load_inputs();
    for (int s = 0; s < 4; s++) begin
      logic [DW-1:0] d;
      d = rnd256();
      wr(3'(2 + s), d);
      sh[s] = d;
    end
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 40 && status_rd_o[0]; t++) @(negedge clk_i);
  endtask

  // timed run: start edge E, then checks at fixed offsets
  task automatic do_run(input logic [1:0] op);
    logic [DW-1:0] n0, n1;
    load_inputs();
    calc(op, n0, n1);
    wr(3'd0, {253'b0, op, 1'b1});
    chk("R4 status after start", DW'(status_rd_o), DW'(32'h1));
    chk("R9 legal start no err", DW'(last_err), '0);
    for (int c = 1; c <= 11; c++) begin
      @(negedge clk_i);
      if (c == 4) begin
        chk("R7 lane0 first", DW'(res0_o[LW-1:0]), DW'(n0[LW-1:0]));
        chk("R8 lane7 kept", DW'(res1_o[DW-1 -: LW]), DW'(exp_r1[DW-1 -: LW]));
      end
      if (c == 7)  chk("R6 ready still low", DW'(status_rd_o), DW'(32'h1));
      if (c == 8)  chk("R6 ready back busy set", DW'(status_rd_o), DW'(32'h3));
      if (c == 10) chk("R7 busy before last", DW'(status_rd_o), DW'(32'h3));
      if (c == 11) chk("R7 busy cleared", DW'(status_rd_o), DW'(32'h2));
    end
    exp_r0 = n0; exp_r1 = n1;
    chk("R5 res0", res0_o, exp_r0);
    chk("R5 res1", res1_o, exp_r1);
    chk("R1 start reads zero", DW'(ctrl_rd_o), DW'({29'b0, op, 1'b0}));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] n0, n1;
    void'($urandom(32'hC0FFEE));
    exp_r0 = '0; exp_r1 = '0;
    for (int s = 0; s < 4; s++) sh[s] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    chk("R3 reset ctrl", DW'(ctrl_rd_o), '0);
    chk("R3 reset status", DW'(status_rd_o), DW'(32'h2));
    chk("R3 reset res", res0_o | res1_o, '0);
    chk("R3 reset err", DW'(err_o), '0);

    // R1 reserved bits and idle op change
    wr(3'd0, {224'b0, 32'hFFFF_FFF4});
    chk("R1 reserved ignored", DW'(ctrl_rd_o), DW'(32'h4));
    chk("R1 no err", DW'(last_err), '0);
    // R9 invalid op while idle
    wr(3'd0, {253'b0, 2'd3, 1'b0});
    chk("R9 op3 err", DW'(last_err), DW'(1));
    chk("R9 op3 not applied", DW'(ctrl_rd_o), DW'(32'h4));
    @(negedge clk_i);
    chk("R9 err one cycle", DW'(err_o), '0);
    // R2 status write ignored
    wr(3'd1, '1);
    chk("R2 status write ignored", DW'(status_rd_o), DW'(32'h2));
    chk("R2 status write no err", DW'(last_err), '0);
    // R12 unused targets
    wr(3'd6, '1);
    chk("R12 target6 no err", DW'(last_err), '0);
    wr(3'd7, '1);
    chk("R12 target7 ctrl", DW'(ctrl_rd_o), DW'(32'h4));
    // R3 engine start resets op
    eng_start_i = 1'b1; @(negedge clk_i); eng_start_i = 1'b0;
    chk("R3 engine start ctrl", DW'(ctrl_rd_o), '0);

    // directed runs, every op
    do_run(2'd0);
    do_run(2'd1);
    do_run(2'd2);
    for (int r = 0; r < 5; r++) do_run(2'($urandom_range(0, 2)));

    // R9/R10 illegal writes during a run
    load_inputs();
    calc(2'd1, n0, n1);
    wr(3'd0, {253'b0, 2'd1, 1'b1});
    wr(3'd0, {253'b0, 2'd1, 1'b1});
    chk("R9 start while busy", DW'(last_err), DW'(1));
    wr(3'd0, {253'b0, 2'd2, 1'b0});
    chk("R9 op change busy", DW'(last_err), DW'(1));
    chk("R9 op kept", DW'(ctrl_rd_o), DW'(32'h2));
    wr(3'd0, {253'b0, 2'd1, 1'b0});
    chk("R9 same op busy ok", DW'(last_err), '0);
    wr(3'd2, '1);
    chk("R10 input not ready err", DW'(last_err), DW'(1));
    for (int t = 0; t < 20 && !status_rd_o[1]; t++) @(negedge clk_i);
    chk("R10 window busy ready", DW'(status_rd_o), DW'(32'h3));
    wr(3'd4, 256'h1234);
    chk("R10 input while ready ok", DW'(last_err), '0);
    sh[2] = 256'h1234;
    wait_idle();
    exp_r0 = n0; exp_r1 = n1;
    chk("R10 dropped write not used r0", res0_o, exp_r0);
    chk("R10 dropped write not used r1", res1_o, exp_r1);

    // R11 abort mid-run, stray strobes ignored
    load_inputs();
    wr(3'd0, {253'b0, 2'd2, 1'b1});
    @(negedge clk_i);
    eng_start_i = 1'b1; @(negedge clk_i); eng_start_i = 1'b0;
    chk("R3 abort status", DW'(status_rd_o), DW'(32'h2));
    chk("R3 abort ctrl", DW'(ctrl_rd_o), '0);
    repeat (15) @(negedge clk_i);
    chk("R11 stray ignored r0", res0_o, exp_r0);
    chk("R11 stray ignored r1", res1_o, exp_r1);
    do_run(2'd2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule